// File: doc/BRIEF.md
# PCI Window Address Translator

This block converts addresses between a local system bus and PCI space for a host bridge. It holds six target windows, each with a power-of-two size, a PCI base and a local base, plus one I/O window base and one downstream memory window given by a start and an end address. A requester presents an address and an operation code. One cycle later the block returns a hit flag, the translated address and the index of the window that matched.

The six target windows serve DMA. A local address that falls inside a window is moved into PCI space at the same offset from the window's PCI base. The downstream memory window is an identity map with a range check. I/O addresses must fall inside a fixed small range, and the I/O window base is then added to them. I/O translation in the other direction is always refused. Software loads all windows through a simple register write port.

Top module: `pci_xlate_unit`

## Requirements
- R1: After reset, rsp_valid, rsp_hit, rsp_addr and rsp_bar are all 0. Every window size, base, the I/O base and the memory start and end are 0, so all target windows are disabled and the memory window is empty.
- R2: A configuration write (cfg_we=1) uses cfg_addr[4:2] to pick a target: values 0 to 5 select target windows 0 to 5, and value 6 selects the global registers. cfg_addr[1:0] picks the field. For a window, field 0 is the size, field 1 the PCI base and field 2 the local base. For the globals, field 0 is the I/O base, field 1 the memory start and field 2 the memory end. Field 3 and selector 7 are ignored. A request issued in the same cycle as a write still sees the old setting.
- R3: Both bases of a window are used only after an AND with ~(size-1), so their low bits have no effect.
- R4: With req_op=2'b01 (local to PCI), window i matches address a when aligned local base <= a < aligned local base + size. The end is computed without wrapping. The result is (a - local base + PCI base) modulo 2^32.
- R5: When several windows match, the one with the lowest index is used, and rsp_bar returns that index.
- R6: A window whose size is 0 never matches.
- R7: A local-to-PCI request that no window matches returns rsp_hit=0 and rsp_addr=0.
- R8: With req_op=2'b10 (I/O toward local), an address from 0x100 to 0x10000 inclusive hits with result address + I/O base. Any other address misses with result 0.
- R9: With req_op=2'b11 (I/O from local), the request always misses and returns 0.
- R10: With req_op=2'b00 (memory toward local), the request hits when memory start <= a < memory end and returns a unchanged. Otherwise it misses with result 0. For every operation other than 2'b01, rsp_bar is 0.
- R11: rsp_valid equals req_valid from the previous cycle. While rsp_valid is 0, rsp_hit, rsp_addr and rsp_bar are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW (5) | Register select: target in the upper bits, field in the low two bits |
| cfg_wdata | input | AW (32) | Configuration write data |
| req_valid | input | 1 | Translation request strobe |
| req_op | input | 2 | Operation code (see R4, R8, R9, R10) |
| req_addr | input | AW (32) | Address to translate |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_hit | output | 1 | Translation accepted |
| rsp_addr | output | AW (32) | Translated address, 0 on a miss |
| rsp_bar | output | IDX_W (3) | Index of the target window that matched |

## Verification
The bench builds the block with its defaults: a 32-bit address and six target windows. The 32-bit width lets one window reach the very top of the address space, which checks that the end of the range is computed without wrapping. With six windows, overlapping windows of different sizes can be placed so that the lowest-index rule decides between them. A disabled window can also sit over addresses that another window serves. The bench mixes directed cases at every range edge of the I/O, memory and target windows with pseudo-random requests and reconfigurations. It checks each of these against its own behavioural model on every clock.

// File: rtl/pci_xlate_pkg.sv
package pci_xlate_pkg;

  typedef enum logic [1:0] {
    OP_MEM_IN  = 2'b00,
    OP_BAR_OUT = 2'b01,
    OP_IO_IN   = 2'b10,
    OP_IO_OUT  = 2'b11
  } xlate_op_e;

  localparam logic [1:0] FLD_SIZE  = 2'd0;
  localparam logic [1:0] FLD_PCI   = 2'd1;
  localparam logic [1:0] FLD_LOC   = 2'd2;

  localparam logic [1:0] FLD_IOBASE = 2'd0;
  localparam logic [1:0] FLD_MSTART = 2'd1;
  localparam logic [1:0] FLD_MEND   = 2'd2;

endpackage

// File: rtl/xlate_cfg_regs.sv
module xlate_cfg_regs
  import pci_xlate_pkg::*;
#(
  parameter int AW     = 32,
  parameter int NWIN   = 6,
  parameter int CFG_AW = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [AW-1:0]             cfg_wdata,
  output logic [NWIN-1:0][AW-1:0]   win_size,
  output logic [NWIN-1:0][AW-1:0]   win_pci,
  output logic [NWIN-1:0][AW-1:0]   win_loc,
  output logic [AW-1:0]             io_base,
  output logic [AW-1:0]             mem_start,
  output logic [AW-1:0]             mem_end
);

  localparam int SEL_W = CFG_AW - 2;
  localparam logic [SEL_W-1:0] SEL_GLB = SEL_W'(NWIN);

  logic [SEL_W-1:0] sel;
  logic [1:0]       fld;

  assign sel = cfg_addr[CFG_AW-1:2];
  assign fld = cfg_addr[1:0];

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    logic          hit_sel;
    logic [AW-1:0] size_d, pci_d, loc_d;
    logic [AW-1:0] size_q, pci_q, loc_q;

    assign hit_sel = cfg_we && (sel == SEL_W'(g));

    always_comb begin
      size_d = size_q;
      pci_d  = pci_q;
      loc_d  = loc_q;
      if (hit_sel) begin
        case (fld)
          FLD_SIZE: size_d = cfg_wdata;
          FLD_PCI:  pci_d  = cfg_wdata;
          FLD_LOC:  loc_d  = cfg_wdata;
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        size_q <= '0;
        pci_q  <= '0;
        loc_q  <= '0;
      end else if (hit_sel) begin
        size_q <= size_d;
        pci_q  <= pci_d;
        loc_q  <= loc_d;
      end
    end

    assign win_size[g] = size_q;
    assign win_pci[g]  = pci_q;
    assign win_loc[g]  = loc_q;
  end

  logic          glb_sel;
  logic [AW-1:0] io_d, ms_d, me_d;
  logic [AW-1:0] io_q, ms_q, me_q;

  assign glb_sel = cfg_we && (sel == SEL_GLB);

  always_comb begin
    io_d = io_q;
    ms_d = ms_q;
    me_d = me_q;
    if (glb_sel) begin
      case (fld)
        FLD_IOBASE: io_d = cfg_wdata;
        FLD_MSTART: ms_d = cfg_wdata;
        FLD_MEND:   me_d = cfg_wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_q <= '0;
      ms_q <= '0;
      me_q <= '0;
    end else if (glb_sel) begin
      io_q <= io_d;
      ms_q <= ms_d;
      me_q <= me_d;
    end
  end

  assign io_base   = io_q;
  assign mem_start = ms_q;
  assign mem_end   = me_q;

endmodule

// File: rtl/xlate_bar_lookup.sv
module xlate_bar_lookup #(
  parameter int AW    = 32,
  parameter int NWIN  = 6,
  parameter int IDX_W = 3
) (
  input  logic [AW-1:0]             addr,
  input  logic [NWIN-1:0][AW-1:0]   win_size,
  input  logic [NWIN-1:0][AW-1:0]   win_pci,
  input  logic [NWIN-1:0][AW-1:0]   win_loc,
  output logic                      hit,
  output logic [IDX_W-1:0]          idx,
  output logic [AW-1:0]             xaddr
);

  logic [NWIN-1:0]         match;
  logic [NWIN-1:0][AW-1:0] cand;

  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    logic [AW-1:0] mask, lbase, pbase;
    logic [AW:0]   lend;

    assign mask  = ~(win_size[g] - AW'(1));
    assign lbase = win_loc[g] & mask;
    assign pbase = win_pci[g] & mask;
    assign lend  = {1'b0, lbase} + {1'b0, win_size[g]};

    assign match[g] = (win_size[g] != '0) && (addr >= lbase) &&
                      ({1'b0, addr} < lend);
    assign cand[g]  = (addr - lbase) + pbase;
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    xaddr = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        idx   = IDX_W'(i);
        xaddr = cand[i];
      end
    end
  end

endmodule

// File: rtl/xlate_range_check.sv
module xlate_range_check #(
  parameter int          AW    = 32,
  parameter logic [31:0] IO_LO = 32'h0000_0100,
  parameter logic [31:0] IO_HI = 32'h0001_0000
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] io_base,
  input  logic [AW-1:0] mem_start,
  input  logic [AW-1:0] mem_end,
  output logic          io_hit,
  output logic [AW-1:0] io_addr,
  output logic          mem_hit
);

  localparam logic [AW-1:0] LO = AW'(IO_LO);
  localparam logic [AW-1:0] HI = AW'(IO_HI);

  assign io_hit  = (addr >= LO) && (addr <= HI);
  assign io_addr = addr + io_base;
  assign mem_hit = (addr >= mem_start) && (addr < mem_end);

endmodule

// File: rtl/pci_xlate_unit.sv
module pci_xlate_unit
  import pci_xlate_pkg::*;
#(
  parameter int          AW     = 32,
  parameter int          NWIN   = 6,
  parameter logic [31:0] IO_LO  = 32'h0000_0100,
  parameter logic [31:0] IO_HI  = 32'h0001_0000,
  localparam int         IDX_W  = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int         CFG_AW = $clog2(NWIN + 1) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [AW-1:0]     req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [AW-1:0]     rsp_addr,
  output logic [IDX_W-1:0]  rsp_bar
);

  logic [NWIN-1:0][AW-1:0] win_size, win_pci, win_loc;
  logic [AW-1:0]           io_base, mem_start, mem_end;

  xlate_cfg_regs #(.AW(AW), .NWIN(NWIN), .CFG_AW(CFG_AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .win_size  (win_size),
    .win_pci   (win_pci),
    .win_loc   (win_loc),
    .io_base   (io_base),
    .mem_start (mem_start),
    .mem_end   (mem_end)
  );

  logic             bar_hit;
  logic [IDX_W-1:0] bar_idx;
  logic [AW-1:0]    bar_addr;

  xlate_bar_lookup #(.AW(AW), .NWIN(NWIN), .IDX_W(IDX_W)) u_bar (
    .addr     (req_addr),
    .win_size (win_size),
    .win_pci  (win_pci),
    .win_loc  (win_loc),
    .hit      (bar_hit),
    .idx      (bar_idx),
    .xaddr    (bar_addr)
  );

  logic          io_hit, mem_hit;
  logic [AW-1:0] io_addr;

  xlate_range_check #(.AW(AW), .IO_LO(IO_LO), .IO_HI(IO_HI)) u_rng (
    .addr      (req_addr),
    .io_base   (io_base),
    .mem_start (mem_start),
    .mem_end   (mem_end),
    .io_hit    (io_hit),
    .io_addr   (io_addr),
    .mem_hit   (mem_hit)
  );

  logic             hit_d, hit_q, vld_q;
  logic [AW-1:0]    addr_d, addr_q;
  logic [IDX_W-1:0] bar_d, bar_q;

  always_comb begin
    hit_d  = 1'b0;
    addr_d = '0;
    bar_d  = '0;
    if (req_valid) begin
      case (xlate_op_e'(req_op))
        OP_MEM_IN: begin
          hit_d  = mem_hit;
          addr_d = mem_hit ? req_addr : '0;
        end
        OP_BAR_OUT: begin
          hit_d  = bar_hit;
          addr_d = bar_addr;
          bar_d  = bar_idx;
        end
        OP_IO_IN: begin
          hit_d  = io_hit;
          addr_d = io_hit ? io_addr : '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      hit_q  <= 1'b0;
      addr_q <= '0;
      bar_q  <= '0;
    end else begin
      vld_q  <= req_valid;
      hit_q  <= hit_d;
      addr_q <= addr_d;
      bar_q  <= bar_d;
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_hit   = hit_q;
  assign rsp_addr  = addr_q;
  assign rsp_bar   = bar_q;

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int          AW     = 32,
  parameter int          NWIN   = 6,
  parameter logic [31:0] IO_LO  = 32'h0000_0100,
  parameter logic [31:0] IO_HI  = 32'h0001_0000,
  parameter int          IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic [AW-1:0]    req_addr,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic [AW-1:0]    rsp_addr,
  input logic [IDX_W-1:0] rsp_bar
);

  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (rsp_valid == $past(req_valid)));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && rsp_addr == '0 && rsp_bar == '0));

  assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_addr == '0));

  assert_io_reject_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(req_valid && req_op == 2'b11)) |-> !rsp_hit);

  assert_mem_identity_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_hit && $past(req_op == 2'b00)) |->
      (rsp_addr == $past(req_addr) && rsp_bar == '0));

  assert_io_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && rsp_hit && $past(req_op == 2'b10)) |->
      ($past(req_addr) >= AW'(IO_LO) && $past(req_addr) <= AW'(IO_HI)));

  assert_bar_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (int'(rsp_bar) < NWIN));

endmodule

bind pci_xlate_unit xlate_checker #(
  .AW(AW), .NWIN(NWIN), .IO_LO(IO_LO), .IO_HI(IO_HI), .IDX_W(IDX_W)
) u_xlate_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_op    (req_op),
  .req_addr  (req_addr),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_addr  (rsp_addr),
  .rsp_bar   (rsp_bar)
);

// File: tb/test_pci_xlate_unit.sv
module test_pci_xlate_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_addr;
  logic [2:0]  rsp_bar;

  always #2 clk = ~clk;

  pci_xlate_unit i_pci_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_addr(rsp_addr),
    .rsp_bar(rsp_bar)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  longint m_size[6], m_pci[6], m_loc[6];
  longint m_io, m_ms, m_me;

  logic        e_valid, e_hit;
  logic [31:0] e_addr;
  logic [2:0]  e_bar;
  string       e_tag;

  task automatic model_write(input logic [4:0] ca, input logic [31:0] wd);
    int s = int'(ca[4:2]);
    int f = int'(ca[1:0]);
    if (s < 6) begin
      if (f == 0) m_size[s] = longint'(wd);
      if (f == 1) m_pci[s]  = longint'(wd);
      if (f == 2) m_loc[s]  = longint'(wd);
    end else if (s == 6) begin
      if (f == 0) m_io = longint'(wd);
      if (f == 1) m_ms = longint'(wd);
      if (f == 2) m_me = longint'(wd);
    end
  endtask

  task automatic model_eval(input logic v, input logic [1:0] op, input logic [31:0] a_in,
                            output string auto_tag);
    longint a = longint'(a_in);
    e_valid = v; e_hit = 0; e_addr = 0; e_bar = 0; auto_tag = "R11";
    if (v) begin
      case (op)
        2'b00: begin
          auto_tag = "R10";
          if (a >= m_ms && a < m_me) begin e_hit = 1; e_addr = a_in; end
        end
        2'b01: begin
          auto_tag = "R7";
          for (int i = 0; i < 6; i++) begin
            longint msk = (~(m_size[i] - 1)) & 64'hFFFF_FFFF;
            longint lb  = m_loc[i] & msk;
            longint pb  = m_pci[i] & msk;
            if (!e_hit && m_size[i] != 0 && a >= lb && a < lb + m_size[i]) begin
              e_hit = 1; e_bar = 3'(i);
              e_addr = 32'((a - lb + pb) & 64'hFFFF_FFFF);
              auto_tag = "R4";
            end
          end
        end
        2'b10: begin
          auto_tag = "R8";
          if (a >= 64'h100 && a <= 64'h10000) begin
            e_hit = 1; e_addr = 32'((a + m_io) & 64'hFFFF_FFFF);
          end
        end
        default: auto_tag = "R9";
      endcase
    end
  endtask

  task automatic compare();
    checks++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_addr !== e_addr || rsp_bar !== e_bar) begin
      errors++;
      $display("FAIL %s: got valid=%0b hit=%0b addr=%h bar=%0d, expected valid=%0b hit=%0b addr=%h bar=%0d",
               e_tag, rsp_valid, rsp_hit, rsp_addr, rsp_bar, e_valid, e_hit, e_addr, e_bar);
    end
  endtask

  task automatic step(input logic we, input logic [4:0] ca, input logic [31:0] wd,
                      input logic v, input logic [1:0] op, input logic [31:0] a,
                      input string tag);
    string at;
    @(negedge clk);
    compare();
    cfg_we = we; cfg_addr = ca; cfg_wdata = wd;
    req_valid = v; req_op = op; req_addr = a;
    model_eval(v, op, a, at);
    e_tag = (tag == "") ? at : tag;
    if (we) model_write(ca, wd);
  endtask

  task automatic wr(input int s, input int f, input logic [31:0] d);
    step(1'b1, {3'(s), 2'(f)}, d, 1'b0, 2'b00, 32'h0, "R2");
  endtask

  task automatic rq(input logic [1:0] op, input logic [31:0] a, input string tag);
    step(1'b0, 5'd0, 32'h0, 1'b1, op, a, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_size[i] = 0; m_pci[i] = 0; m_loc[i] = 0; end
    m_io = 0; m_ms = 0; m_me = 0;
    e_valid = 0; e_hit = 0; e_addr = 0; e_bar = 0; e_tag = "R1";
    rst_n = 0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
    req_valid = 0; req_op = 0; req_addr = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;

    // R1: reset state; nothing configured
    rq(2'b01, 32'h0000_0000, "R1");
    rq(2'b00, 32'h0000_0000, "R1");
    rq(2'b10, 32'h0000_0100, "R8");
    rq(2'b10, 32'h0000_00FF, "R8");
    rq(2'b10, 32'h0001_0000, "R8");
    rq(2'b10, 32'h0001_0001, "R8");
    rq(2'b11, 32'h0000_0200, "R9");

    // R2 / R3: window 0 with unaligned bases
    wr(0, 0, 32'h0000_1000);
    wr(0, 1, 32'h4000_0123);
    wr(0, 2, 32'h1000_0FFF);
    rq(2'b01, 32'h1000_0000, "R3");
    rq(2'b01, 32'h1000_0FFF, "R3");
    rq(2'b01, 32'h1000_1000, "R7");
    rq(2'b01, 32'h0FFF_FFFF, "R7");

    // R5: overlapping window 1, larger
    wr(1, 0, 32'h0001_0000);
    wr(1, 1, 32'h8000_0000);
    wr(1, 2, 32'h1000_0000);
    rq(2'b01, 32'h1000_0800, "R5");
    rq(2'b01, 32'h1000_2000, "R5");
    rq(2'b01, 32'h1000_FFFF, "R4");

    // R6: window 2 size 0 over free space; window 3 behind it
    wr(2, 1, 32'h5000_0000);
    wr(2, 2, 32'h2000_0000);
    rq(2'b01, 32'h2000_0000, "R6");
    wr(3, 0, 32'h0000_0100);
    wr(3, 1, 32'h6000_0000);
    wr(3, 2, 32'h2000_0000);
    rq(2'b01, 32'h2000_0010, "R6");

    // R4: window 5 reaching the top of the space
    wr(5, 0, 32'h1000_0000);
    wr(5, 1, 32'h0000_0000);
    wr(5, 2, 32'hF000_0000);
    rq(2'b01, 32'hFFFF_FFFF, "R4");
    rq(2'b01, 32'hF000_0000, "R4");

    // R2: field 3 and selector 7 ignored
    step(1'b1, {3'd0, 2'd3}, 32'hFFFF_FFFF, 1'b0, 2'b00, 32'h0, "R2");
    step(1'b1, {3'd7, 2'd0}, 32'hFFFF_FFFF, 1'b0, 2'b00, 32'h0, "R2");
    rq(2'b01, 32'h1000_0004, "R2");
    rq(2'b00, 32'h0000_0000, "R2");

    // R2: request in the same cycle as a write sees the old value
    step(1'b1, {3'd0, 2'd1}, 32'h7000_0000, 1'b1, 2'b01, 32'h1000_0010, "R2");
    rq(2'b01, 32'h1000_0010, "R2");

    // Globals: I/O base and memory window
    wr(6, 0, 32'hA000_0000);
    wr(6, 1, 32'h3000_0000);
    wr(6, 2, 32'h4000_0000);
    rq(2'b10, 32'h0000_0100, "R8");
    rq(2'b10, 32'h0001_0000, "R8");
    rq(2'b10, 32'h0000_00FF, "R8");
    rq(2'b11, 32'h0000_0400, "R9");
    rq(2'b00, 32'h3000_0000, "R10");
    rq(2'b00, 32'h3FFF_FFFF, "R10");
    rq(2'b00, 32'h4000_0000, "R10");
    rq(2'b00, 32'h2FFF_FFFF, "R10");

    // R11: idle cycles between requests
    step(1'b0, 5'd0, 32'h0, 1'b0, 2'b01, 32'h1000_0000, "R11");
    rq(2'b01, 32'h1000_0000, "R4");
    step(1'b0, 5'd0, 32'h0, 1'b0, 2'b10, 32'h0000_0200, "R11");

    // Pseudo-random mix with reconfiguration
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom_range(0, 9));
      if (r == 0) begin
        int w = int'($urandom_range(0, 5));
        int f = int'($urandom_range(0, 3));
        logic [31:0] d = $urandom();
        if (f == 0) d = ($urandom_range(0, 3) == 0) ? 32'h0 : (32'h1 << $urandom_range(4, 28));
        step(1'b1, {3'(w), 2'(f)}, d, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             32'h1000_0000 + 32'($urandom_range(0, 32'h0002_0000)), "");
      end else begin
        logic [31:0] a;
        int k = int'($urandom_range(0, 3));
        if (k == 0) a = $urandom();
        else if (k == 1) a = 32'($urandom_range(0, 32'h0001_0200));
        else if (k == 2) a = m_loc[$urandom_range(0, 5)][31:0] + 32'($urandom_range(0, 32'h2000)) - 32'h1000;
        else a = 32'h1000_0000 + 32'($urandom_range(0, 32'h0002_0000));
        step(1'b0, 5'd0, 32'h0, 1'($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), a, "");
      end
    end

    @(negedge clk);
    compare();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule